// File: doc/BRIEF.md
# Expanded-Memory Block Translator

This unit gives a 16-bit real-mode machine an expanded-memory pool without a fixed window. The first megabyte of the CPU address space is cut into 64 blocks of 16 KB. Each block owns one mapping entry, which holds an 8-bit pool page number and an enable flag. When the mapping is active and the block may be remapped, a CPU memory access to that block goes to the pool page. Otherwise the access goes to default system memory at its own address.

Software programs the entries only through I/O writes to four adjacent ports. One port picks the entry, one stores the page number, one stores the enable flag, and a write to the fourth port switches the whole scheme on. Nothing can be read back. The translation itself is combinational. It takes the upper CPU address bits and returns two chip selects and the upper address bits for the memory array, with no added wait state.

Top module: `ems_page_mapper`

## Requirements
- R1: A write to port E8h loads the entry index from data bits 5:0 and ignores data bits 7:6. Block number n covers CPU addresses n*16 KB to n*16 KB + 16 KB - 1, so the block number is address bits 19:14.
- R2: A write to port EAh stores all 8 data bits as the pool page number of the entry that the index selects.
- R3: A write to port EBh sets the enable flag of the selected entry from data bit 7 and ignores bits 6:0.
- R4: A write to port E9h with any data turns the mapping on, and it stays on until reset. While it is off, every access selects system memory.
- R5: If the mapping is on, the block may be remapped and its flag is set, then the pool select is 1, the system select is 0, and the output address bits 23:14 equal the page number zero-extended.
- R6: Only blocks 0–39 (00000h–9FFFFh) and 52–59 (D0000h–EFFFFh) may be remapped. All other blocks select system memory whatever their entry holds.
- R7: An access at or above 1 MB (address bits 23:20 not zero) selects system memory, and the output address bits equal the CPU address bits 23:14.
- R8: The outputs follow the CPU address in the same cycle. A register write changes the translation from the clock edge that captures it, so an access in the same cycle as the write still sees the old entry.
- R9: If a block's flag is cleared, the block again selects system memory, with the output address equal to the CPU address.
- R10: Writes to any port outside E8h–EBh, and port addresses presented while the write strobe is low, change no entry, no index and no enable state.
- R11: Reset turns the mapping off. It sets the index to 0 and clears every page number and every enable flag.
- R12: In every cycle, exactly one of the two chip selects is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | I/O write strobe, one cycle per write |
| ioAddr | input | 16 | I/O port address |
| ioWrData | input | 8 | I/O write data |
| cpuAddrHi | input | 10 | CPU memory address bits 23:14 |
| selSys | output | 1 | Chip select for default system memory |
| selPool | output | 1 | Chip select for the expanded-memory pool |
| memAddrHi | output | 10 | Translated memory address bits 23:14 |

## Verification
An entry update and a memory access to the same block can fall in the same cycle. The bench provokes this by driving a page-port write while the CPU address points into the block the index selects. Before the edge, the outputs must show the old page number. After that edge, with the address held, they must show the new one. Around this case the bench sweeps all 64 blocks and a set of addresses above 1 MB. It compares each result with an entry model updated from the port writes alone.

// File: rtl/ems_map_pkg.sv
`timescale 1ns/1ps
package ems_map_pkg;
  localparam int OFS_W    = 14;
  localparam int LOWMEG_W = 20;
  localparam int IDX_W    = LOWMEG_W - OFS_W;
  localparam int NUM_BLK  = 1 << IDX_W;
  localparam int DATA_W   = 8;
  localparam int PAGE_W   = 8;
  localparam int ENA_BIT  = 7;

  localparam int CONV_END_BLK  = 'hA0000 >> OFS_W;
  localparam int UPPER_BEG_BLK = 'hD0000 >> OFS_W;
  localparam int UPPER_END_BLK = 'hF0000 >> OFS_W;

  typedef enum logic [1:0] {
    PORT_INDEX = 2'd0,
    PORT_ARM   = 2'd1,
    PORT_PAGE  = 2'd2,
    PORT_FLAG  = 2'd3
  } portSelT;

  typedef struct packed {
    logic              globalOn;
    logic              ldPage;
    logic              ldFlag;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } emsWrT;

  function automatic logic regionAllowed(input logic [IDX_W-1:0] blk);
    int b;
    b = int'(blk);
    return (b < CONV_END_BLK) || ((b >= UPPER_BEG_BLK) && (b < UPPER_END_BLK));
  endfunction
endpackage

// File: rtl/ems_map_ctrl.sv
`timescale 1ns/1ps
module ems_map_ctrl
  import ems_map_pkg::*;
#(
  parameter int              IO_W      = 16,
  parameter logic [IO_W-1:0] PORT_BASE = 'hE8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic [IO_W-1:0]   ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  output emsWrT             wr
);
  logic             quadHit;
  portSelT          portSel;
  logic             ldIdx;
  logic             armHit;
  logic [IDX_W-1:0] idxQ;
  logic             globalQ;

  // The four ports occupy one aligned group; the low two bits pick the function.
  assign quadHit = ioWrEn && (ioAddr[IO_W-1:2] == PORT_BASE[IO_W-1:2]);
  assign portSel = portSelT'(ioAddr[1:0]);
  assign ldIdx   = quadHit && (portSel == PORT_INDEX);
  assign armHit  = quadHit && (portSel == PORT_ARM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ    <= '0;
      globalQ <= 1'b0;
    end else begin
      if (ldIdx)  idxQ    <= ioWrData[IDX_W-1:0];
      if (armHit) globalQ <= 1'b1;
    end
  end

  always_comb begin
    wr.globalOn = globalQ;
    wr.ldPage   = quadHit && (portSel == PORT_PAGE);
    wr.ldFlag   = quadHit && (portSel == PORT_FLAG);
    wr.idx      = idxQ;
    wr.data     = ioWrData;
  end

  // R1: index takes only the low data bits
  a_r1_index_load: assert property (@(posedge clk) disable iff (!rstN)
    ldIdx |=> idxQ == $past(ioWrData[IDX_W-1:0]));

  // R4: once armed the mapping stays on
  a_r4_global_sticky: assert property (@(posedge clk) disable iff (!rstN)
    globalQ |=> globalQ);

  // R10: writes outside the port group leave control state alone
  a_r10_foreign_port: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && (ioAddr[IO_W-1:2] != PORT_BASE[IO_W-1:2])) |=> ($stable(idxQ) && $stable(globalQ)));
endmodule

// File: rtl/ems_map_dpath.sv
`timescale 1ns/1ps
module ems_map_dpath
  import ems_map_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int UP_W  = ADDR_W - OFS_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  emsWrT                   wr,
  input  logic [ADDR_W-1:OFS_W]   cpuAddrHi,
  output logic                    selSys,
  output logic                    selPool,
  output logic [ADDR_W-1:OFS_W]   memAddrHi
);
  logic [PAGE_W-1:0]  pageQ [NUM_BLK];
  logic [NUM_BLK-1:0] flagQ;
  logic [IDX_W-1:0]   blk;
  logic               inLowMeg;
  logic               remapHit;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pageQ[g] <= '0;
        flagQ[g] <= 1'b0;
      end else if (wr.idx == IDX_W'(g)) begin
        if (wr.ldPage) pageQ[g] <= wr.data[PAGE_W-1:0];
        if (wr.ldFlag) flagQ[g] <= wr.data[ENA_BIT];
      end
    end
  end

  assign blk      = cpuAddrHi[LOWMEG_W-1:OFS_W];
  assign inLowMeg = (cpuAddrHi[ADDR_W-1:LOWMEG_W] == '0);
  assign remapHit = wr.globalOn && inLowMeg && regionAllowed(blk) && flagQ[blk];

  always_comb begin
    selPool   = remapHit;
    selSys    = !remapHit;
    memAddrHi = remapHit ? {{(UP_W-PAGE_W){1'b0}}, pageQ[blk]} : cpuAddrHi;
  end

  // R2: page write lands in the indexed entry
  a_r2_page_store: assert property (@(posedge clk) disable iff (!rstN)
    wr.ldPage |=> pageQ[$past(wr.idx)] == $past(wr.data[PAGE_W-1:0]));

  // R3: flag write takes bit 7 only
  a_r3_flag_store: assert property (@(posedge clk) disable iff (!rstN)
    wr.ldFlag |=> flagQ[$past(wr.idx)] == $past(wr.data[ENA_BIT]));

  // R4: nothing reaches the pool while the mapping is off
  a_r4_off_default: assert property (@(posedge clk) disable iff (!rstN)
    !wr.globalOn |-> (selSys && !selPool));

  // R7: accesses above the first megabyte pass straight through
  a_r7_high_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddrHi[ADDR_W-1:LOWMEG_W] != '0) |-> (selSys && memAddrHi == cpuAddrHi));
endmodule

// File: rtl/ems_page_mapper.sv
`timescale 1ns/1ps
module ems_page_mapper
  import ems_map_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter int              IO_W      = 16,
  parameter logic [IO_W-1:0] PORT_BASE = 'hE8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ioWrEn,
  input  logic [IO_W-1:0]       ioAddr,
  input  logic [DATA_W-1:0]     ioWrData,
  input  logic [ADDR_W-1:OFS_W] cpuAddrHi,
  output logic                  selSys,
  output logic                  selPool,
  output logic [ADDR_W-1:OFS_W] memAddrHi
);
  emsWrT wrBus;

  ems_map_ctrl #(.IO_W(IO_W), .PORT_BASE(PORT_BASE)) i_ctrl (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .wr(wrBus)
  );

  ems_map_dpath #(.ADDR_W(ADDR_W)) i_dpath (
    .clk(clk), .rstN(rstN), .wr(wrBus), .cpuAddrHi(cpuAddrHi),
    .selSys(selSys), .selPool(selPool), .memAddrHi(memAddrHi)
  );

  // R12: exactly one memory target per cycle
  a_r12_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $countones({selSys, selPool}) == 1);
endmodule

// File: tb/test_ems_page_mapper.sv
`timescale 1ns/1ps
module test_ems_page_mapper;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ioWrEn = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic [23:14] cpuAddrHi = '0;
  logic       selSys, selPool;
  logic [23:14] memAddrHi;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0] expPage [64];
  logic       expFlag [64];
  logic       expOn;
  logic [5:0] expIdx;

  always #10 clk = ~clk;

  ems_page_mapper i_ems_page_mapper (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .cpuAddrHi(cpuAddrHi),
    .selSys(selSys), .selPool(selPool), .memAddrHi(memAddrHi)
  );

  function automatic bit allowedBlk(int b);
    return (b < 40) || (b >= 52 && b < 60);
  endfunction

  task automatic modelReset();
    for (int b = 0; b < 64; b++) begin
      expPage[b] = 8'h00;
      expFlag[b] = 1'b0;
    end
    expOn  = 1'b0;
    expIdx = 6'd0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioWrEn = 1'b1; ioAddr = a; ioWrData = d;
    @(negedge clk);
    ioWrEn = 1'b0;
    if (a == 16'h00E8) expIdx = d[5:0];
    else if (a == 16'h00E9) expOn = 1'b1;
    else if (a == 16'h00EA) expPage[expIdx] = d;
    else if (a == 16'h00EB) expFlag[expIdx] = d[7];
  endtask

  task automatic checkAddr(input logic [9:0] hi, input string req);
    bit hit;
    logic [9:0] eAddr;
    int b;
    cpuAddrHi = hi;
    #1;
    b = int'(hi[5:0]);
    hit = expOn && (hi[9:6] == 4'h0) && allowedBlk(b) && expFlag[b];
    eAddr = hit ? {2'b00, expPage[b]} : hi;
    nChecks++;
    if (selPool !== hit || selSys !== !hit || memAddrHi !== eAddr) begin
      nFails++;
      $display("FAIL %s addrHi=%h: got sys=%b pool=%b out=%h, expected sys=%b pool=%b out=%h",
               req, hi, selSys, selPool, memAddrHi, !hit, hit, eAddr);
    end
  endtask

  task automatic sweepAll(input string req);
    for (int b = 0; b < 64; b++) checkAddr({4'h0, 6'(b)}, req);
    for (int k = 1; k < 16; k++) checkAddr({4'(k), 6'((k * 13) & 63)}, {req, "/R7"});
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    modelReset();
    doReset();
    // R11 reset state: everything to system memory
    sweepAll("R11");

    // R1 R2 R3: program every entry, index upper bits set, flag noise in low bits
    for (int b = 0; b < 64; b++) begin
      ioWrite(16'h00E8, 8'hC0 | 8'(b));
      ioWrite(16'h00EA, 8'((b * 37 + 5) & 255));
      ioWrite(16'h00EB, (b % 3 != 2) ? 8'h95 : 8'h7F);
    end
    // R4 still off before arming
    sweepAll("R4");

    // R4 arm with zero data; R5 R6 R3 R2 R1 translation sweep
    ioWrite(16'h00E9, 8'h00);
    sweepAll("R5_R6");

    // R10 foreign ports and strobe-low cycles
    ioWrite(16'h00E8, 8'd5);
    ioWrite(16'h01E8, 8'd9);
    ioWrite(16'h00E7, 8'd9);
    ioWrite(16'h00EC, 8'hFF);
    ioWrite(16'h00EF, 8'h00);
    ioWrite(16'h10EB, 8'h00);
    @(negedge clk);
    ioAddr = 16'h00E8; ioWrData = 8'd9; ioWrEn = 1'b0;
    @(negedge clk);
    ioAddr = 16'h00EB; ioWrData = 8'h00;
    @(negedge clk);
    ioWrite(16'h00EA, 8'hAA);
    sweepAll("R10");

    // R8 same-cycle write and access to the indexed block
    ioWrite(16'h00E8, 8'd3);
    @(negedge clk);
    ioWrEn = 1'b1; ioAddr = 16'h00EA; ioWrData = 8'h5C;
    checkAddr(10'd3, "R8_before_edge");
    @(posedge clk);
    #1;
    ioWrEn = 1'b0;
    expPage[3] = 8'h5C;
    checkAddr(10'd3, "R8_after_edge");

    // R9 clear flag returns to default, set again restores page
    ioWrite(16'h00EB, 8'h00);
    checkAddr(10'd3, "R9_cleared");
    checkAddr(10'h043, "R9_high_same_low_bits");
    ioWrite(16'h00EB, 8'h80);
    checkAddr(10'd3, "R9_restored");

    // R6 disallowed block with flag set stays default
    ioWrite(16'h00E8, 8'd45);
    ioWrite(16'h00EB, 8'h80);
    checkAddr(10'd45, "R6_video_block");
    ioWrite(16'h00E8, 8'd62);
    ioWrite(16'h00EB, 8'h80);
    checkAddr(10'd62, "R6_bios_block");

    // R11 mid-run reset clears everything; arming alone maps nothing
    doReset();
    sweepAll("R11_after_reset");
    ioWrite(16'h00E9, 8'hFF);
    sweepAll("R11_armed_empty");
    // R11 index is 0 after reset, page cleared to 0
    ioWrite(16'h00EB, 8'h80);
    sweepAll("R11_index_zero");
    // R12 covered in every check by selSys/selPool comparison

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule